// File: doc/BRIEF.md
# Multi-Bank SDRAM Command Legality Checker

This block watches the command pins of a double-data-rate SDRAM bus and reports each command that the memory would not accept. It decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command. It keeps a small state machine and a down-counter for each of four banks. It compares every new command with the state of the bank it addresses and with the bursts that the other banks have in flight.

The block is passive and is meant to sit beside a memory controller in simulation or in silicon debug logic. For each sampled command it reports three things one cycle later: the decoded command code, a pulse with a reason code when the command breaks a rule, and a flag when a read cuts into a write burst, so that write data must be masked. It also exposes the state of every bank. Parameters set the activate-to-column delay, the precharge time and the burst duration, all counted in clock cycles.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is decoded and checked only when the clock-enable input was high on the previous and on the current sampled edge. Otherwise `cmd_code_o` reports 9 (skipped) and `illegal_o` stays low. After reset `cmd_code_o` is 9, `illegal_o` and `mask_req_o` are 0, and every bank state is 0.
- R2: Command codes, with chip-select low and RAS/CAS/WE levels given: chip-select high = 0 (deselect); HHH = 1 (no operation); LHH = 2 (activate); HLH = 3 (read); HLL = 4 (write); LHL = 5 (precharge); HHL = 6 (burst terminate); LLH = 7 (auto refresh); LLL = 8 (mode register set). Each result appears on `cmd_code_o` one cycle after the edge that sampled the command.
- R3: Deselect and no-operation are always legal and start nothing. An idle bank stays idle until it is activated. Bank state codes are: 0 idle, 1 row activating/active, 2 precharging, 3 read burst, 4 write burst, 5 read with auto precharge, 6 write with auto precharge.
- R4: Auto refresh and mode register set are legal only when all four banks are idle. Otherwise they are reported with reason 1.
- R5: Activate is legal to an idle bank, or to a precharging bank once T_RP cycles have passed since its precharge. Earlier than that it gets reason 4. Activate to a bank in any other state gets reason 2.
- R6: A read or write to a bank in state 1 before T_RCD cycles have passed since its activate gets reason 3. A legal read or write puts the bank into state 5 or 6 when address bit 10 is high, and into state 3 or 4 when it is low.
- R7: A plain burst lasts BURST_CYC cycles and then returns the bank to state 1. An auto-precharge burst lasts BURST_CYC cycles, then spends T_RP cycles in state 2, then returns to state 0.
- R8: Burst terminate is legal only toward a bank in state 3 or 4, and it returns that bank to state 1. Toward any other bank it gets reason 5.
- R9: A write while any bank, the addressed bank included, is in a plain read burst gets reason 6.
- R10: A legal read issued while any bank is in a plain write burst raises `mask_req_o`. Any other read does not.
- R11: While a bank is in state 5 or 6, a read or write to another bank gets reason 7. A precharge or activate to another bank stays legal. Read, write, precharge or burst terminate toward that bank itself is illegal, with reason 2 for read, write and precharge, and reason 5 for burst terminate.
- R12: An illegal command changes no bank state and raises `illegal_o` for one cycle with a non-zero reason and with `mask_req_o` low. When several rules fail, a fault of the addressed bank's own state or timing takes priority over a conflict with another bank.
- R13: A legal read or write ends any plain read or write burst in the other banks, which return to state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the command pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock-enable pin level |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10: auto-precharge select on read and write |
| cmd_code_o | output | 4 | Decoded command of the previous sampled edge |
| bank_state_o | output | 12 | Three-bit state per bank, bank 0 in bits 2:0 |
| illegal_o | output | 1 | One-cycle pulse for a rule violation |
| reason_o | output | 4 | Violation reason, 0 when legal |
| mask_req_o | output | 1 | A read cut into a write burst; write data needs masking |

## Verification
Each result is due in the cycle that follows the edge at which the command was sampled. That edge also loads the bank counters. A burst therefore occupies exactly BURST_CYC observed cycles before the bank changes state, and a column command counts as ready exactly T_RCD edges after its activate. The bench changes the pins on the falling edge, waits for one rising edge and reads every output on the next falling edge. The sweeps insert 0 to 3 idle cycles before a timed command, and the expected verdict in each case is the comparison of the inserted gap plus one against the parameter. Every ordered pair of distinct banks is driven through the same cross-bank sequence.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_BST   = 4'd6,
        CMD_REF   = 4'd7,
        CMD_MRS   = 4'd8,
        CMD_SKIP  = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE   = 3'd0,
        BK_ROW    = 3'd1,
        BK_PRECHG = 3'd2,
        BK_RD     = 3'd3,
        BK_WR     = 3'd4,
        BK_RDA    = 3'd5,
        BK_WRA    = 3'd6
    } bank_st_e;

    typedef enum logic [3:0] {
        RSN_NONE     = 4'd0,
        RSN_NOT_IDLE = 4'd1,
        RSN_STATE    = 4'd2,
        RSN_TRCD     = 4'd3,
        RSN_TRP      = 4'd4,
        RSN_BST      = 4'd5,
        RSN_RDWR     = 4'd6,
        RSN_AUTOPRE  = 4'd7
    } reason_e;

    typedef struct packed {
        logic    cke;
        cmd_e    cmd;
        logic    illegal;
        reason_e reason;
        logic    mask;
    } out_regs_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    always_comb begin
        cmd_o = CMD_SKIP;
        if (cke_prev_i && cke_i) begin
            if (cs_n_i) begin
                cmd_o = CMD_DESEL;
            end else begin
                case ({ras_n_i, cas_n_i, we_n_i})
                    3'b111:  cmd_o = CMD_NOP;
                    3'b110:  cmd_o = CMD_BST;
                    3'b101:  cmd_o = CMD_RD;
                    3'b100:  cmd_o = CMD_WR;
                    3'b011:  cmd_o = CMD_ACT;
                    3'b010:  cmd_o = CMD_PRE;
                    3'b001:  cmd_o = CMD_REF;
                    default: cmd_o = CMD_MRS;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_chk_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_CYC = 4,
    parameter int CNT_W     = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     apply_i,
    input  cmd_e     cmd_i,
    input  logic     tgt_i,
    input  logic     ap_i,
    output bank_st_e state_o,
    output logic     ready_o
);

    localparam logic [CNT_W-1:0] TRCD_LD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] TRP_LD   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] BURST_LD = CNT_W'(BURST_CYC - 1);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } bank_regs_t;

    bank_regs_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (bank_q.cnt != '0) begin
            bank_d.cnt = bank_q.cnt - 1'b1;
        end else begin
            case (bank_q.st)
                BK_PRECHG:    bank_d.st = BK_IDLE;
                BK_RD, BK_WR: bank_d.st = BK_ROW;
                BK_RDA, BK_WRA: begin
                    bank_d.st  = BK_PRECHG;
                    bank_d.cnt = TRP_LD;
                end
                default: ;
            endcase
        end
        if (apply_i) begin
            if (tgt_i) begin
                case (cmd_i)
                    CMD_ACT: begin
                        bank_d.st  = BK_ROW;
                        bank_d.cnt = TRCD_LD;
                    end
                    CMD_RD: begin
                        bank_d.st  = ap_i ? BK_RDA : BK_RD;
                        bank_d.cnt = BURST_LD;
                    end
                    CMD_WR: begin
                        bank_d.st  = ap_i ? BK_WRA : BK_WR;
                        bank_d.cnt = BURST_LD;
                    end
                    CMD_PRE: begin
                        if (bank_q.st == BK_ROW || bank_q.st == BK_RD || bank_q.st == BK_WR) begin
                            bank_d.st  = BK_PRECHG;
                            bank_d.cnt = TRP_LD;
                        end
                    end
                    CMD_BST: begin
                        bank_d.st  = BK_ROW;
                        bank_d.cnt = '0;
                    end
                    default: ;
                endcase
            end else if ((cmd_i == CMD_RD || cmd_i == CMD_WR) &&
                         (bank_q.st == BK_RD || bank_q.st == BK_WR)) begin
                bank_d.st  = BK_ROW;
                bank_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '{st: BK_IDLE, cnt: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign state_o = bank_q.st;
    assign ready_o = (bank_q.cnt == '0);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == BK_IDLE && !(apply_i && tgt_i && cmd_i == CMD_ACT)) |=> (bank_q.st == BK_IDLE));

    // R6
    trcd_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && tgt_i && (cmd_i == CMD_RD || cmd_i == CMD_WR) && bank_q.st == BK_ROW) |-> ready_o);

    // R8
    bst_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && tgt_i && cmd_i == CMD_BST) |-> (bank_q.st == BK_RD || bank_q.st == BK_WR));

    // R11
    ap_no_interrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_q.st == BK_RDA || bank_q.st == BK_WRA) && apply_i && tgt_i) |->
        (cmd_i != CMD_RD && cmd_i != CMD_WR && cmd_i != CMD_BST && cmd_i != CMD_PRE));

endmodule

// File: rtl/sdram_cmd_legal.sv
module sdram_cmd_legal
    import sdram_chk_pkg::*;
#(
    parameter int BA_W = 2,
    parameter int NB   = 4
) (
    input  cmd_e            cmd_i,
    input  logic [BA_W-1:0] ba_i,
    input  bank_st_e        st_i  [NB],
    input  logic            rdy_i [NB],
    output logic            illegal_o,
    output reason_e         reason_o,
    output logic            mask_o
);

    logic     all_idle, oth_rd, oth_wr, oth_ap, trdy;
    bank_st_e tst;
    reason_e  rsn;

    always_comb begin
        all_idle = 1'b1;
        oth_rd   = 1'b0;
        oth_wr   = 1'b0;
        oth_ap   = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (st_i[i] != BK_IDLE) all_idle = 1'b0;
            if (BA_W'(i) != ba_i) begin
                if (st_i[i] == BK_RD) oth_rd = 1'b1;
                if (st_i[i] == BK_WR) oth_wr = 1'b1;
                if (st_i[i] == BK_RDA || st_i[i] == BK_WRA) oth_ap = 1'b1;
            end
        end
        tst    = st_i[ba_i];
        trdy   = rdy_i[ba_i];
        rsn    = RSN_NONE;
        mask_o = 1'b0;
        case (cmd_i)
            CMD_REF, CMD_MRS: begin
                if (!all_idle) rsn = RSN_NOT_IDLE;
            end
            CMD_ACT: begin
                if (tst == BK_PRECHG) begin
                    if (!trdy) rsn = RSN_TRP;
                end else if (tst != BK_IDLE) begin
                    rsn = RSN_STATE;
                end
            end
            CMD_RD: begin
                if (tst == BK_ROW) begin
                    if (!trdy) rsn = RSN_TRCD;
                end else if (tst != BK_RD && tst != BK_WR) begin
                    rsn = RSN_STATE;
                end
                if (rsn == RSN_NONE && oth_ap) rsn = RSN_AUTOPRE;
                mask_o = (rsn == RSN_NONE) && (tst == BK_WR || oth_wr);
            end
            CMD_WR: begin
                if (tst == BK_ROW) begin
                    if (!trdy) rsn = RSN_TRCD;
                end else if (tst == BK_RD) begin
                    rsn = RSN_RDWR;
                end else if (tst != BK_WR) begin
                    rsn = RSN_STATE;
                end
                if (rsn == RSN_NONE && oth_rd) rsn = RSN_RDWR;
                if (rsn == RSN_NONE && oth_ap) rsn = RSN_AUTOPRE;
            end
            CMD_PRE: begin
                if (tst == BK_RDA || tst == BK_WRA) rsn = RSN_STATE;
            end
            CMD_BST: begin
                if (tst != BK_RD && tst != BK_WR) rsn = RSN_BST;
            end
            default: ;
        endcase
        reason_o  = rsn;
        illegal_o = (rsn != RSN_NONE);
    end

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_CYC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cke_i,
    input  logic                        cs_n_i,
    input  logic                        ras_n_i,
    input  logic                        cas_n_i,
    input  logic                        we_n_i,
    input  logic [BA_W-1:0]             ba_i,
    input  logic                        a10_i,
    output logic [3:0]                  cmd_code_o,
    output logic [(1<<BA_W)*3-1:0]      bank_state_o,
    output logic                        illegal_o,
    output logic [3:0]                  reason_o,
    output logic                        mask_req_o
);

    localparam int NB     = 1 << BA_W;
    localparam int ST_W   = $bits(bank_st_e);
    localparam int MAX_AB = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAX_T  = (MAX_AB > BURST_CYC) ? MAX_AB : BURST_CYC;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    out_regs_t regs_d, regs_q;
    cmd_e      cmd_dec;
    bank_st_e  bank_st  [NB];
    logic      bank_rdy [NB];
    logic      lg_illegal, lg_mask;
    reason_e   lg_reason;
    logic      any_busy;

    sdram_cmd_decode u_decode (
        .cke_prev_i (regs_q.cke),
        .cke_i      (cke_i),
        .cs_n_i     (cs_n_i),
        .ras_n_i    (ras_n_i),
        .cas_n_i    (cas_n_i),
        .we_n_i     (we_n_i),
        .cmd_o      (cmd_dec)
    );

    sdram_cmd_legal #(.BA_W(BA_W), .NB(NB)) u_legal (
        .cmd_i     (cmd_dec),
        .ba_i      (ba_i),
        .st_i      (bank_st),
        .rdy_i     (bank_rdy),
        .illegal_o (lg_illegal),
        .reason_o  (lg_reason),
        .mask_o    (lg_mask)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        sdram_bank_track #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .BURST_CYC (BURST_CYC),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .apply_i (!lg_illegal),
            .cmd_i   (cmd_dec),
            .tgt_i   (ba_i == BA_W'(g)),
            .ap_i    (a10_i),
            .state_o (bank_st[g]),
            .ready_o (bank_rdy[g])
        );
        assign bank_state_o[g*ST_W +: ST_W] = bank_st[g];
    end

    always_comb begin
        regs_d         = regs_q;
        regs_d.cke     = cke_i;
        regs_d.cmd     = cmd_dec;
        regs_d.illegal = lg_illegal;
        regs_d.reason  = lg_reason;
        regs_d.mask    = lg_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{cke: 1'b0, cmd: CMD_SKIP, illegal: 1'b0, reason: RSN_NONE, mask: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cmd_code_o = regs_q.cmd;
    assign illegal_o  = regs_q.illegal;
    assign reason_o   = regs_q.reason;
    assign mask_req_o = regs_q.mask;

    always_comb begin
        any_busy = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (bank_st[i] != BK_IDLE) any_busy = 1'b1;
        end
    end

    // R1
    cke_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_i |=> (cmd_code_o == CMD_SKIP && !illegal_o));

    // R3
    nop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_dec == CMD_DESEL || cmd_dec == CMD_NOP) |=> !illegal_o);

    // R4
    refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_dec == CMD_REF || cmd_dec == CMD_MRS) && any_busy) |=> (illegal_o && reason_o == RSN_NOT_IDLE));

    // R12
    reason_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (reason_o != RSN_NONE && !mask_req_o));

    // R10
    mask_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_req_o |-> (cmd_code_o == CMD_RD));

endmodule

// File: tb/sdram_cmd_checker_tb_top.sv
module sdram_cmd_checker_tb_top;

    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int BURST = 4;

    localparam int C_DESEL = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4;
    localparam int C_PRE = 5, C_BST = 6, C_REF = 7, C_MRS = 8, C_SKIP = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic        a10 = 1'b0;
    logic [3:0]  cmd_code;
    logic [11:0] bank_state;
    logic        illegal, mask_req;
    logic [3:0]  reason;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdram_cmd_checker #(.BA_W(2), .T_RCD(T_RCD), .T_RP(T_RP), .BURST_CYC(BURST)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke_i        (cke),
        .cs_n_i       (cs_n),
        .ras_n_i      (ras_n),
        .cas_n_i      (cas_n),
        .we_n_i       (we_n),
        .ba_i         (ba),
        .a10_i        (a10),
        .cmd_code_o   (cmd_code),
        .bank_state_o (bank_state),
        .illegal_o    (illegal),
        .reason_o     (reason),
        .mask_req_o   (mask_req)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bst(int i);
        return int'(bank_state[i*3 +: 3]);
    endfunction

    task automatic issue(int c, int b, bit ap);
        ba  = 2'(b);
        a10 = ap;
        case (c)
            C_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            C_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            C_BST:   {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        endcase
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nops(int n);
        for (int k = 0; k < n; k++) issue(C_NOP, 0, 1'b0);
    endtask

    task automatic verdict(string req, int exp_ill, int exp_rsn);
        chk({req, " illegal"}, int'(illegal), exp_ill);
        chk({req, " reason"}, int'(reason), exp_rsn);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all R): actual 200000 cycles expected fewer");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset cmd", int'(cmd_code), C_SKIP);
        chk("R1 reset illegal", int'(illegal), 0);
        chk("R1 reset mask", int'(mask_req), 0);
        chk("R1 reset banks", int'(bank_state), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 clock-enable gating
        issue(C_BST, 0, 1'b0);
        chk("R1 cke low cmd", int'(cmd_code), C_SKIP);
        chk("R1 cke low illegal", int'(illegal), 0);
        cke = 1'b1;
        issue(C_BST, 0, 1'b0);
        chk("R1 cke first high cmd", int'(cmd_code), C_SKIP);
        chk("R1 cke first high illegal", int'(illegal), 0);
        issue(C_REF, 0, 1'b0);
        chk("R1 cke steady cmd", int'(cmd_code), C_REF);
        verdict("R4 refresh all idle", 0, 0);

        // R2 decode sweep on idle banks (R3, R4, R8)
        for (int c = 0; c <= 8; c++) begin
            if (c == C_ACT || c == C_RD || c == C_WR) continue;
            issue(c, c % 4, 1'b0);
            chk("R2 decode", int'(cmd_code), c);
            verdict("R3 R4 R8 idle sweep", (c == C_BST) ? 1 : 0, (c == C_BST) ? 5 : 0);
            chk("R3 banks stay idle", int'(bank_state), 0);
        end

        // R6 activate-to-column sweep, R7 burst and precharge lengths
        for (int g = 0; g < 4; g++) begin
            issue(C_ACT, g, 1'b0);
            chk("R2 act code", int'(cmd_code), C_ACT);
            chk("R5 act to idle", int'(illegal), 0);
            chk("R5 row state", bst(g), 1);
            nops(g);
            issue(C_RD, g, 1'b0);
            chk("R2 read code", int'(cmd_code), C_RD);
            if (1 + g < T_RCD) begin
                verdict("R6 early read", 1, 3);
                chk("R12 early read keeps row", bst(g), 1);
            end else begin
                verdict("R6 timely read", 0, 0);
                chk("R10 plain read no mask", int'(mask_req), 0);
                chk("R6 read state", bst(g), 3);
                nops(BURST - 1);
                chk("R7 burst still running", bst(g), 3);
                nops(1);
                chk("R7 burst over", bst(g), 1);
            end
            nops(2);
            issue(C_PRE, g, 1'b0);
            chk("R7 precharging", bst(g), 2);
            nops(T_RP - 1);
            chk("R7 precharge running", bst(g), 2);
            nops(1);
            chk("R7 back to idle", bst(g), 0);
        end

        // R5 precharge-to-activate sweep
        for (int gap = 0; gap < 4; gap++) begin
            issue(C_ACT, 0, 1'b0);
            nops(T_RCD);
            issue(C_ACT, 0, 1'b0);
            verdict("R5 act to open row", 1, 2);
            issue(C_PRE, 0, 1'b0);
            nops(gap);
            issue(C_ACT, 0, 1'b0);
            if (1 + gap < T_RP) verdict("R5 early act", 1, 4);
            else                verdict("R5 timely act", 0, 0);
            nops(T_RCD);
            issue(C_PRE, 0, 1'b0);
            nops(T_RP + 1);
            chk("R5 sweep ends idle", int'(bank_state), 0);
        end

        // Cross-bank sequence over every ordered pair
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a == b) continue;
                issue(C_ACT, a, 1'b0);
                issue(C_ACT, b, 1'b0);
                issue(C_REF, 0, 1'b0);
                verdict("R4 refresh busy", 1, 1);
                nops(2);
                issue(C_WR, a, 1'b0);
                verdict("R6 write", 0, 0);
                chk("R6 write state", bst(a), 4);
                issue(C_RD, b, 1'b0);
                verdict("R10 read over write", 0, 0);
                chk("R10 mask", int'(mask_req), 1);
                chk("R13 write ended", bst(a), 1);
                issue(C_WR, a, 1'b0);
                verdict("R9 write during read", 1, 6);
                chk("R12 state a kept", bst(a), 1);
                chk("R12 state b kept", bst(b), 3);
                issue(C_BST, a, 1'b0);
                verdict("R8 terminate wrong bank", 1, 5);
                issue(C_BST, b, 1'b0);
                verdict("R8 terminate owner", 0, 0);
                chk("R8 owner to row", bst(b), 1);
                issue(C_RD, a, 1'b1);
                verdict("R6 read auto precharge", 0, 0);
                chk("R6 auto precharge state", bst(a), 5);
                issue(C_WR, b, 1'b0);
                verdict("R11 write vs auto precharge", 1, 7);
                issue(C_PRE, a, 1'b0);
                verdict("R11 precharge into auto burst", 1, 2);
                issue(C_PRE, b, 1'b0);
                verdict("R11 precharge other bank", 0, 0);
                nops(6);
                chk("R7 all idle after auto precharge", int'(bank_state), 0);
            end
        end

        issue(C_MRS, 0, 1'b0);
        verdict("R4 mode set all idle", 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule